// File: doc/BRIEF.md
# Flash Strobe Timing Generator

This block produces the chip-enable, read-strobe and write-strobe waveforms for one byte transfer at a time on a parallel flash device. Every phase length comes from one packed timing word. The word holds seven cycle-count fields of different widths. A transfer request picks a read or a write. The block holds the matching strobe low for the programmed low count and then high for the programmed high count. On a read it captures the device byte as the read strobe rises. It then pulses `done` and holds off further requests for a programmed turnaround.

The first access after reset inserts a chip-enable-to-access delay. Chip enable is then held asserted, so later accesses start their strobe at once. A request can be flagged as one that leaves the device busy. For such a request, the block waits a programmed delay during which it ignores the ready/busy pin. It then waits for the pin to report ready before the turnaround starts. A field value of zero counts as one cycle.

Top module: `flash_strobe_timer`

## Requirements
- R1: The timing word carries these fields: setup delay in bits 25:24, busy delay in 23:19, turnaround in 18:16, read-high in 15:12, read-low in 11:8, write-high in 7:4, write-low in 3:0. Each field is a count of clock cycles, and a field value of 0 gives the same length as a value of 1.
- R2: While reset is held and after it is released, `ce_n`, `re_n` and `we_n` are 1, `ready` is 1, `done` is 0 and `rd_byte` is 0.
- R3: `ce_n` goes to 0 in the cycle after the first accepted request and stays 0 until reset. The first access after reset keeps both strobes high for the setup-delay count before its strobe falls. On every later access, the strobe falls in the cycle right after acceptance.
- R4: A read (`req_write`=0) drives `re_n` low for the read-low count and then high for the read-high count. `we_n` stays 1 throughout.
- R5: A write (`req_write`=1) drives `we_n` low for the write-low count and then high for the write-high count. `dq_out` equals the accepted `wr_byte` and `dq_oe` is 1 throughout both phases. `re_n` stays 1.
- R6: On a read, `rd_byte` takes the value of `flash_din` sampled at the clock edge where `re_n` rises. A write leaves `rd_byte` unchanged.
- R7: `done` is a one-cycle pulse in the cycle that follows the last high-phase cycle.
- R8: For a request with `req_busy`=0, `ready` is 0 for exactly the turnaround count of cycles, starting with the `done` cycle, and then returns to 1.
- R9: For a request with `req_busy`=1, the high phase is followed by the busy-delay count of cycles during which `rb_ready` is ignored. The block then waits at least one cycle, until it samples `rb_ready`=1 (1 = device ready). The turnaround follows.
- R10: Requests are accepted only while `ready` is 1. A request held while `ready` is 0 starts no access. Both strobes are 1 whenever `ready` is 1.
- R11: The timing word is sampled when a request is accepted. Changing it during an access does not alter that access.
- R12: `re_n` and `we_n` are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request, taken when `ready` is 1 |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_busy | input | 1 | Access leaves the device busy; apply the busy wait |
| wr_byte | input | 8 | Byte to write |
| timing_word | input | 26 | Packed phase counts (field layout in R1) |
| rb_ready | input | 1 | Device ready/busy pin, 1 = ready |
| flash_din | input | 8 | Data bus from the device |
| ce_n | output | 1 | Chip enable, active low |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| dq_out | output | 8 | Data bus toward the device |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| rd_byte | output | 8 | Last byte captured on a read |
| done | output | 1 | One-cycle end-of-access pulse |
| ready | output | 1 | Idle, a new request may be presented |

## Verification
The block is built with its package constants: a 5-bit phase counter and 8-bit data. The bench therefore reaches every field at its minimum (zero, counted as one), at its maximum (31 busy cycles, 15 strobe cycles), and at random values between them. On busy accesses the ready/busy pin rises before the busy delay expires, exactly at its end, and well after it. This exercises both the masking window and the polling exit. The timing word is scrambled right after every acceptance, and requests are held asserted through a whole access, so the sampling and hold-off rules are tested on every run.

// File: rtl/fst_pkg.sv
package fst_pkg;

    localparam int BYTE_W = 8;
    localparam int TW_W   = 26;
    localparam int CNT_W  = 5;

    typedef struct packed {
        logic [1:0] setup;
        logic [4:0] busy;
        logic [2:0] turn;
        logic [3:0] rd_hi;
        logic [3:0] rd_lo;
        logic [3:0] wr_hi;
        logic [3:0] wr_lo;
    } fst_timing_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_BUSY,
        PH_POLL,
        PH_TURN
    } fst_phase_t;

    typedef struct packed {
        logic              write;
        logic              busy;
        logic [BYTE_W-1:0] data;
    } fst_op_t;

    function automatic fst_timing_t fst_unpack(input logic [TW_W-1:0] w);
        return fst_timing_t'(w);
    endfunction

    // zero counts as a single cycle
    function automatic logic [CNT_W-1:0] fst_len(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic logic [CNT_W-1:0] fst_low_len(input fst_timing_t t, input logic wr);
        return fst_len(wr ? CNT_W'(t.wr_lo) : CNT_W'(t.rd_lo));
    endfunction

    function automatic logic [CNT_W-1:0] fst_high_len(input fst_timing_t t, input logic wr);
        return fst_len(wr ? CNT_W'(t.wr_hi) : CNT_W'(t.rd_hi));
    endfunction

endpackage

// File: rtl/fst_cycle_timer.sv
module fst_cycle_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= W'(1);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt > W'(1)) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expire = (cnt == W'(1));

    // a phase of zero length would hang the sequencer
    assert_load_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));
    assert_count_live_R1: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);

endmodule

// File: rtl/fst_strobe_decode.sv
module fst_strobe_decode
    import fst_pkg::*;
(
    input  fst_phase_t phase,
    input  logic       write,
    input  logic       ce_on,
    output logic       ce_n,
    output logic       re_n,
    output logic       we_n,
    output logic       dq_oe,
    output logic       ready
);
    always_comb begin
        ce_n  = !ce_on;
        re_n  = !((phase == PH_LOW) && !write);
        we_n  = !((phase == PH_LOW) && write);
        dq_oe = write && ((phase == PH_LOW) || (phase == PH_HIGH));
        ready = (phase == PH_IDLE);
    end
endmodule

// File: rtl/flash_strobe_timer.sv
module flash_strobe_timer
    import fst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_busy,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [TW_W-1:0]   timing_word,
    input  logic              rb_ready,
    input  logic [BYTE_W-1:0] flash_din,
    output logic              ce_n,
    output logic              re_n,
    output logic              we_n,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              done,
    output logic              ready
);
    fst_phase_t       ph, ph_nxt;
    fst_op_t          op;
    fst_timing_t      tmg_q, tmg_live;
    logic             ce_on;
    logic             accept;
    logic             tm_load;
    logic [CNT_W-1:0] tm_val;
    logic             tm_exp;

    assign tmg_live = fst_unpack(timing_word);

    fst_cycle_timer #(.W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .expire   (tm_exp)
    );

    fst_strobe_decode i_decode (
        .phase (ph),
        .write (op.write),
        .ce_on (ce_on),
        .ce_n  (ce_n),
        .re_n  (re_n),
        .we_n  (we_n),
        .dq_oe (dq_oe),
        .ready (ready)
    );

    always_comb begin
        ph_nxt  = ph;
        accept  = 1'b0;
        tm_load = 1'b0;
        tm_val  = CNT_W'(1);
        case (ph)
            PH_IDLE: if (req_valid) begin
                accept  = 1'b1;
                tm_load = 1'b1;
                if (!ce_on) begin
                    ph_nxt = PH_SETUP;
                    tm_val = fst_len(CNT_W'(tmg_live.setup));
                end else begin
                    ph_nxt = PH_LOW;
                    tm_val = fst_low_len(tmg_live, req_write);
                end
            end
            PH_SETUP: if (tm_exp) begin
                ph_nxt  = PH_LOW;
                tm_load = 1'b1;
                tm_val  = fst_low_len(tmg_q, op.write);
            end
            PH_LOW: if (tm_exp) begin
                ph_nxt  = PH_HIGH;
                tm_load = 1'b1;
                tm_val  = fst_high_len(tmg_q, op.write);
            end
            PH_HIGH: if (tm_exp) begin
                tm_load = 1'b1;
                if (op.busy) begin
                    ph_nxt = PH_BUSY;
                    tm_val = fst_len(CNT_W'(tmg_q.busy));
                end else begin
                    ph_nxt = PH_TURN;
                    tm_val = fst_len(CNT_W'(tmg_q.turn));
                end
            end
            PH_BUSY: if (tm_exp) begin
                ph_nxt = PH_POLL;
            end
            PH_POLL: if (rb_ready) begin
                ph_nxt  = PH_TURN;
                tm_load = 1'b1;
                tm_val  = fst_len(CNT_W'(tmg_q.turn));
            end
            PH_TURN: if (tm_exp) begin
                ph_nxt = PH_IDLE;
            end
            default: ph_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            op      <= '0;
            tmg_q   <= '0;
            ce_on   <= 1'b0;
            rd_byte <= '0;
            done    <= 1'b0;
        end else begin
            ph   <= ph_nxt;
            done <= (ph == PH_HIGH) && tm_exp;
            if (accept) begin
                op    <= '{write: req_write, busy: req_busy, data: wr_byte};
                tmg_q <= tmg_live;
                ce_on <= 1'b1;
            end
            if ((ph == PH_LOW) && tm_exp && !op.write) begin
                rd_byte <= flash_din;
            end
        end
    end

    assign dq_out = op.data;

    assert_strobe_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(!re_n && !we_n));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ready |-> (re_n && we_n));
    assert_ce_held_R3: assert property (@(posedge clk) disable iff (rst)
        !ce_n |=> !ce_n);
    assert_poll_waits_R9: assert property (@(posedge clk) disable iff (rst)
        ((ph == PH_POLL) && !rb_ready) |=> (ph == PH_POLL));
    assert_capture_edge_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_byte) |-> $rose(re_n));

endmodule

// File: tb/test_flash_strobe_timer.sv
module test_flash_strobe_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_busy, rb_ready;
    logic [7:0]  wr_byte, flash_din;
    logic [25:0] timing_word;
    logic        ce_n, re_n, we_n, dq_oe, done, ready;
    logic [7:0]  dq_out, rd_byte;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [7:0] exp_rd = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_strobe_timer i_flash_strobe_timer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_busy(req_busy), .wr_byte(wr_byte), .timing_word(timing_word),
        .rb_ready(rb_ready), .flash_din(flash_din), .ce_n(ce_n), .re_n(re_n),
        .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .rd_byte(rd_byte),
        .done(done), .ready(ready)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // starts and ends at a falling edge with ready=1
    task automatic run_op(input string tag, input bit wr, input bit bsy,
                          input logic [25:0] tw, input logic [7:0] val,
                          input int rpin, input bit first, input bit hold);
        int pre, low, high, nrdy, dones, d, other_bad, dq_bad, ce_bad, quiet_bad;
        int e_pre, e_lo, e_hi, e_rdy, e_b, e_t;
        bit seen_low, seen_done, finished;
        logic sl, ot;
        pre = 0; low = 0; high = 0; nrdy = 0; dones = 0; d = 0;
        other_bad = 0; dq_bad = 0; ce_bad = 0; quiet_bad = 0;
        seen_low = 0; seen_done = 0; finished = 0;
        e_pre = first ? eff(int'(tw[25:24])) : 0;
        e_lo  = wr ? eff(int'(tw[3:0])) : eff(int'(tw[11:8]));
        e_hi  = wr ? eff(int'(tw[7:4])) : eff(int'(tw[15:12]));
        e_b   = eff(int'(tw[23:19]));
        e_t   = eff(int'(tw[18:16]));
        e_rdy = bsy ? (((e_b + 1) > rpin ? (e_b + 1) : rpin) + e_t) : e_t;

        req_valid = 1'b1; req_write = wr; req_busy = bsy; wr_byte = val;
        timing_word = tw; flash_din = val; rb_ready = !bsy;
        @(negedge clk);
        timing_word = 26'($urandom);  // R11: later changes must not matter
        if (hold) req_write = !wr; else req_valid = 1'b0;
        for (int n = 0; n < 400 && !finished; n++) begin
            sl = wr ? we_n : re_n;
            ot = wr ? re_n : we_n;
            if (ot == 1'b0) other_bad++;
            if (ce_n != 1'b0) ce_bad++;
            if (done) dones++;
            if (!seen_done) begin
                if (done) begin
                    seen_done = 1; d = 1; nrdy = 1;
                end else if (sl == 1'b0) begin
                    low++; seen_low = 1;
                    if (wr && (!dq_oe || dq_out != val)) dq_bad++;
                end else if (!seen_low) begin
                    pre++;
                end else begin
                    high++;
                    if (wr && (!dq_oe || dq_out != val)) dq_bad++;
                    flash_din = ~val;
                end
            end else if (ready) begin
                finished = 1;
            end else begin
                d++; nrdy++;
            end
            if (!finished) begin
                if (bsy) rb_ready = seen_done && (d >= rpin);
                @(negedge clk);
            end
        end
        if (hold) req_valid = 1'b0;
        if (!wr) exp_rd = val;
        chk(tag, "ready returned", int'(finished), 1);
        chk("R3", "cycles before strobe", pre, e_pre);
        chk("R3", "chip enable held low", ce_bad, 0);
        chk(wr ? "R5" : "R4", "strobe low cycles (R11 latched word)", low, e_lo);
        chk(wr ? "R5" : "R4", "strobe high cycles (R11 latched word)", high, e_hi);
        chk("R12", "opposite strobe low", other_bad, 0);
        chk("R7", "done pulses", dones, 1);
        chk(bsy ? "R9" : "R8", "not-ready cycles from done", nrdy, e_rdy);
        chk("R6", "read byte", int'(rd_byte), int'(exp_rd));
        if (wr) chk("R5", "data bus drive", dq_bad, 0);
        chk(tag, "tagged access ok", int'((low == e_lo) && (high == e_hi)), 1);
        if (hold) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (!re_n || !we_n || !ready) quiet_bad++;
            end
            chk("R10", "held request started nothing", quiet_bad, 0);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        rst = 1'b1; req_valid = 0; req_write = 0; req_busy = 0;
        wr_byte = 0; flash_din = 0; timing_word = 0; rb_ready = 1;
        repeat (3) @(negedge clk);
        chk("R2", "ce_n in reset", int'(ce_n), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R2", "ce_n after reset", int'(ce_n), 1);
        chk("R2", "strobes idle", int'(re_n & we_n), 1);
        chk("R2", "ready", int'(ready), 1);
        chk("R2", "done", int'(done), 0);
        chk("R2", "rd_byte", int'(rd_byte), 0);

        // first read with a long setup delay
        run_op("R3", 0, 0, {2'd3, 5'd2, 3'd4, 4'd5, 4'd3, 4'd2, 4'd6}, 8'hA5, 0, 1, 0);
        // write leaves the read byte alone
        run_op("R6", 1, 0, {2'd1, 5'd1, 3'd2, 4'd4, 4'd2, 4'd7, 4'd3}, 8'h3C, 0, 0, 0);
        // all-zero word: every phase one cycle
        run_op("R1", 0, 0, 26'd0, 8'h5A, 0, 0, 0);
        run_op("R1", 1, 0, 26'd0, 8'hC3, 0, 0, 0);
        // all-ones word: maximum counts
        run_op("R1", 0, 0, 26'h3FF_FFFF, 8'h81, 0, 0, 0);
        // busy: pin claims ready during the mask window
        run_op("R9", 1, 1, {2'd0, 5'd9, 3'd2, 4'd1, 4'd1, 4'd2, 4'd2}, 8'h11, 1, 0, 0);
        // busy: pin rises exactly after the window, then well after
        run_op("R9", 0, 1, {2'd0, 5'd4, 3'd3, 4'd2, 4'd2, 4'd1, 4'd1}, 8'h22, 5, 0, 0);
        run_op("R9", 1, 1, {2'd0, 5'd31, 3'd1, 4'd1, 4'd1, 4'd1, 4'd1}, 8'h33, 45, 0, 0);
        // request held through the access
        run_op("R10", 0, 0, {2'd0, 5'd0, 3'd5, 4'd3, 4'd2, 4'd1, 4'd1}, 8'h44, 0, 0, 1);
        run_op("R10", 1, 0, {2'd0, 5'd0, 3'd0, 4'd1, 4'd1, 4'd2, 4'd3}, 8'h55, 0, 0, 1);

        for (int i = 0; i < 40; i++) begin
            run_op("R11", 1'($urandom), 1'($urandom), 26'($urandom), 8'($urandom),
                   int'($urandom_range(0, 40)), 0, 1'($urandom_range(0, 3) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule